// File: doc/BRIEF.md
# Serial EEPROM Command Controller with Write Guarding

This block is a mode-0 serial-peripheral slave placed in front of a 512-byte, 8-bit-wide storage array. The bus master lowers chip select and shifts in an 8-bit instruction. Depending on the instruction, an address byte and data bytes follow. Read data leaves most significant bit first on the serial output. The storage is a register array. A write-cycle timer stands in for the programming time of a nonvolatile cell, and during that time the page buffer is copied into the array.

The array is 512 bytes, so its address needs nine bits. The ninth bit does not travel in the address byte: it is carried in bit 3 of the read and write instructions. Every change to stored state is gated in three ways. The master must first set a write-enable latch with its own instruction. A two-bit protection field in the status register can fence off the upper quarter, the upper half or the whole array. A write-guard input pin, when held low, blocks every store.

All bus pins are sampled by the system clock through a synchronizer. The serial clock must therefore stay low and stay high for several system clocks in each half period.

Top module: `eeprom_spi_ctrl`

## Requirements
- R1: After reset the status byte reads 8'h00, every array byte reads 8'h00, and the serial output and its enable are low.
- R2: Instruction 8'h06 sets the write-enable latch and 8'h04 clears it. The latch is visible as status bit 1.
- R3: An array write or a status write issued while the latch is clear changes nothing and starts no write cycle.
- R4: Instruction 8'h03 or 8'h0B is followed by an address byte. Data is then returned MSB first, beginning at that address and incrementing after every byte. The address wraps from 9'h1FF to 9'h000.
- R5: Bit 3 of the read instruction (8'h0B) and of the write instruction (8'h0A) supplies address bit 8.
- R6: Instruction 8'h02 or 8'h0A is followed by an address byte and data bytes. The bytes land at successive addresses that wrap inside the aligned 16-byte page. Beyond 16 bytes, a later byte overwrites the earlier one at the same position.
- R7: A write is committed at chip-select rise only if at least one data byte was received and no partial byte was clocked in. Otherwise nothing changes, no write cycle starts, and the latch keeps its value.
- R8: Instruction 8'h05 returns the status byte {4'b0, guard[1:0], latch, busy}, repeated for as long as the master keeps clocking. Instruction 8'h01 followed by a byte sets guard from bits 3:2 of that byte and ignores its other bits.
- R9: Guard 2'b01 blocks array writes to 9'h180 through 9'h1FF. Guard 2'b10 blocks 9'h100 through 9'h1FF. Guard 2'b11 blocks the whole array. A blocked write changes nothing, starts no write cycle, and leaves the latch set. Guard 2'b00 blocks nothing, and guard never blocks a status write.
- R10: While the write-guard pin is low, array writes and status writes are both blocked.
- R11: An accepted write clears the latch and holds status bit 0 high for WRITE_CYCLES clocks. During that time every instruction except 8'h05 is ignored.
- R12: The serial-output enable is high only while read or status data is being shifted out, and it drops after chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all bus pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_en | output | 1 | High while spi_miso carries data |
| wp_n | input | 1 | Write-guard pin; low blocks all stores |

## Verification
The hardest state to reach from the pins is a write cycle that is still running when the next transactions arrive. The bench starts a write and, while the cycle is running, sends a write-enable instruction and then a full array read. It then confirms that the read produced no data and that the latch stayed clear once the cycle ended. The commit condition is exercised in its less common forms. Three stray clock bits after a data byte must block the commit, as must a write that ends after the address byte. The latch state seen in the status byte shows that no write cycle began. The protection window is probed on both sides of each boundary.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_ADDR,
      ST_RDATA,
      ST_WDATA,
      ST_SRD,
      ST_SWR,
      ST_SKIP
   } ctl_state_t;

   localparam logic [7:0] OP_LATCH_SET = 8'h06;
   localparam logic [7:0] OP_LATCH_CLR = 8'h04;
   localparam logic [7:0] OP_STAT_RD   = 8'h05;
   localparam logic [7:0] OP_STAT_WR   = 8'h01;
   localparam logic [7:0] OP_ARR_RD    = 8'h03;
   localparam logic [7:0] OP_ARR_WR    = 8'h02;
   localparam logic [7:0] OP_HI_BIT    = 8'h08;

endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("eeprom_pin_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic [WIDTH-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= pin_in;
         end
         assign pin_q = q;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {STAGES{RST_VAL}};
            else        q <= {q[STAGES-2:0], pin_in};
         end
         assign pin_q = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/eeprom_byte_store.sv
module eeprom_byte_store #(
   parameter int DEPTH  = 512,
   parameter int DATA_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [DEPTH];

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("eeprom_byte_store: DEPTH must be a power of two");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/eeprom_write_timer.sv
module eeprom_write_timer #(
   parameter int WRITE_CYCLES = 1000,
   parameter int PAGE_BYTES   = 16,
   localparam int CW = $clog2(WRITE_CYCLES + 1),
   localparam int PW = $clog2(PAGE_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          drain_req,
   output logic          busy,
   output logic          drain_act,
   output logic [PW-1:0] slot
);

   localparam logic [CW-1:0] LAST = CW'(WRITE_CYCLES - 1);

   logic          busy_q;
   logic          drain_q;
   logic [CW-1:0] elapsed;

   generate
      if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_len
         $error("eeprom_write_timer: WRITE_CYCLES must cover one page drain");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         drain_q <= 1'b0;
         elapsed <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q  <= 1'b1;
            drain_q <= drain_req;
            elapsed <= '0;
         end
      end else if (elapsed == LAST) begin
         busy_q  <= 1'b0;
         drain_q <= 1'b0;
      end else begin
         elapsed <= elapsed + 1'b1;
      end
   end

   assign busy      = busy_q;
   assign drain_act = busy_q && drain_q && (elapsed < CW'(PAGE_BYTES));
   assign slot      = elapsed[PW-1:0];

   p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q) |=> busy_q);
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && elapsed != LAST) |=> busy_q);
   p_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && elapsed == LAST) |=> !busy_q);

endmodule

// File: rtl/eeprom_spi_ctrl.sv
module eeprom_spi_ctrl
   import eeprom_spi_pkg::*;
#(
   parameter int DEPTH        = 512,
   parameter int PAGE_BYTES   = 16,
   parameter int WRITE_CYCLES = 1000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic spi_miso_en,
   input  logic wp_n
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = $clog2(PAGE_BYTES);
   localparam logic [AW-1:0] QTR_BASE  = AW'(DEPTH - DEPTH / 4);
   localparam logic [AW-1:0] HALF_BASE = AW'(DEPTH / 2);

   generate
      if (DEPTH != 512) begin : g_bad_depth
         $error("eeprom_spi_ctrl: address framing carries exactly nine bits");
      end
      if (PAGE_BYTES < 2 || PAGE_BYTES > 256 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("eeprom_spi_ctrl: PAGE_BYTES must be a power of two up to 256");
      end
   endgenerate

   // pin synchronizer: bit 0 chip select, 1 clock, 2 data in, 3 write guard
   logic [3:0] pins_s;
   eeprom_pin_sync #(
      .WIDTH  (4),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b1001)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_in({wp_n, spi_mosi, spi_sck, spi_cs_n}),
      .pin_q (pins_s)
   );

   logic cs_s, sck_s, mosi_s, wp_s;
   assign cs_s   = pins_s[0];
   assign sck_s  = pins_s[1];
   assign mosi_s = pins_s[2];
   assign wp_s   = pins_s[3];

   logic cs_d, sck_d;
   logic cs_rise, cs_fall, sck_rise, sck_fall;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end
   assign cs_rise  = cs_s & ~cs_d;
   assign cs_fall  = ~cs_s & cs_d;
   assign sck_rise = sck_s & ~sck_d & ~cs_s;
   assign sck_fall = ~sck_s & sck_d & ~cs_s;

   ctl_state_t     state;
   logic [2:0]     bit_cnt;
   logic [6:0]     rx_sr;
   logic [7:0]     rx_byte;
   logic           a8;
   logic           is_wr;
   logic [AW-1:0]  addr;
   logic [PW-1:0]  wr_cnt;
   logic [PW-1:0]  wr_idx;
   logic [7:0]     page_buf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] page_vld;
   logic           have_data;
   logic [1:0]     guard_new;
   logic           wel;
   logic [1:0]     guard;
   logic [7:0]     tx_sr;
   logic           miso_q;
   logic           tx_live;
   logic [7:0]     status;

   logic           busy;
   logic           drain_act;
   logic [PW-1:0]  slot;
   logic           mem_we;
   logic [AW-1:0]  mem_waddr;
   logic [AW-1:0]  mem_raddr;
   logic [7:0]     mem_rdata;

   logic           byte_done;
   logic           commit_arr;
   logic           commit_sr;

   function automatic logic in_guard(input logic [1:0] g, input logic [AW-1:0] a);
      case (g)
         2'b01:   return a >= QTR_BASE;
         2'b10:   return a >= HALF_BASE;
         2'b11:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   assign rx_byte   = {rx_sr, mosi_s};
   assign byte_done = sck_rise && (state != ST_IDLE) && (bit_cnt == 3'd7);
   assign wr_idx    = addr[PW-1:0] + wr_cnt;
   assign status    = {4'b0000, guard, wel, busy};
   assign tx_live   = (state == ST_RDATA) || (state == ST_SRD);

   assign commit_arr = cs_rise && (state == ST_WDATA) && have_data && (bit_cnt == 3'd0)
                       && wel && wp_s && !in_guard(guard, addr);
   assign commit_sr  = cs_rise && (state == ST_SWR) && have_data && (bit_cnt == 3'd0)
                       && wel && wp_s;

   assign mem_raddr = (state == ST_ADDR) ? {a8, rx_byte} : addr;
   assign mem_we    = drain_act && page_vld[slot];
   assign mem_waddr = {addr[AW-1:PW], slot};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         rx_sr     <= '0;
         a8        <= 1'b0;
         is_wr     <= 1'b0;
         addr      <= '0;
         wr_cnt    <= '0;
         page_vld  <= '0;
         have_data <= 1'b0;
         guard_new <= '0;
         wel       <= 1'b0;
         guard     <= '0;
         tx_sr     <= '0;
         miso_q    <= 1'b0;
         for (int i = 0; i < PAGE_BYTES; i++) page_buf[i] <= '0;
      end else if (cs_fall) begin
         state   <= ST_CMD;
         bit_cnt <= '0;
      end else if (cs_rise) begin
         state  <= ST_IDLE;
         miso_q <= 1'b0;
         if (commit_arr || commit_sr) wel <= 1'b0;
         if (commit_sr) guard <= guard_new;
      end else if (sck_rise && state != ST_IDLE) begin
         rx_sr   <= rx_byte[6:0];
         bit_cnt <= bit_cnt + 1'b1;
         if (byte_done) begin
            case (state)
               ST_CMD: begin
                  if (busy) begin
                     if (rx_byte == OP_STAT_RD) begin
                        state <= ST_SRD;
                        tx_sr <= status;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end else if (rx_byte == OP_LATCH_SET) begin
                     wel   <= 1'b1;
                     state <= ST_SKIP;
                  end else if (rx_byte == OP_LATCH_CLR) begin
                     wel   <= 1'b0;
                     state <= ST_SKIP;
                  end else if (rx_byte == OP_STAT_RD) begin
                     state <= ST_SRD;
                     tx_sr <= status;
                  end else if (rx_byte == OP_STAT_WR) begin
                     state     <= ST_SWR;
                     have_data <= 1'b0;
                  end else if ((rx_byte & ~OP_HI_BIT) == OP_ARR_RD) begin
                     a8    <= rx_byte[3];
                     is_wr <= 1'b0;
                     state <= ST_ADDR;
                  end else if ((rx_byte & ~OP_HI_BIT) == OP_ARR_WR) begin
                     a8    <= rx_byte[3];
                     is_wr <= 1'b1;
                     state <= ST_ADDR;
                  end else begin
                     state <= ST_SKIP;
                  end
               end
               ST_ADDR: begin
                  if (is_wr) begin
                     addr      <= {a8, rx_byte};
                     wr_cnt    <= '0;
                     page_vld  <= '0;
                     have_data <= 1'b0;
                     state     <= ST_WDATA;
                  end else begin
                     tx_sr <= mem_rdata;
                     addr  <= {a8, rx_byte} + 1'b1;
                     state <= ST_RDATA;
                  end
               end
               ST_RDATA: begin
                  tx_sr <= mem_rdata;
                  addr  <= addr + 1'b1;
               end
               ST_WDATA: begin
                  page_buf[wr_idx] <= rx_byte;
                  page_vld[wr_idx] <= 1'b1;
                  wr_cnt           <= wr_cnt + 1'b1;
                  have_data        <= 1'b1;
               end
               ST_SRD: begin
                  tx_sr <= status;
               end
               ST_SWR: begin
                  guard_new <= rx_byte[3:2];
                  have_data <= 1'b1;
               end
               default: ;
            endcase
         end
      end else if (sck_fall && tx_live) begin
         miso_q <= tx_sr[7];
         tx_sr  <= {tx_sr[6:0], 1'b0};
      end
   end

   eeprom_write_timer #(
      .WRITE_CYCLES(WRITE_CYCLES),
      .PAGE_BYTES  (PAGE_BYTES)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (commit_arr || commit_sr),
      .drain_req(commit_arr),
      .busy     (busy),
      .drain_act(drain_act),
      .slot     (slot)
   );

   eeprom_byte_store #(
      .DEPTH (DEPTH),
      .DATA_W(8)
   ) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(page_buf[slot]),
      .raddr(mem_raddr),
      .rdata(mem_rdata)
   );

   assign spi_miso    = miso_q;
   assign spi_miso_en = tx_live;

   // a store into the array never touches a guarded region
   p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !(guard == 2'b11 || (guard == 2'b10 && mem_waddr[AW-1])
                   || (guard == 2'b01 && mem_waddr[AW-1:AW-2] == 2'b11)));
   p_latch_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wel);
   p_latch_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel));
   p_pin_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wp_s));
   p_out_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !spi_miso_en);

endmodule

// File: tb/tb_eeprom_spi_ctrl.sv
`timescale 1ns/1ps
module tb_eeprom_spi_ctrl;

   localparam int HP = 8;
   localparam int WC = 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic wp_n = 1'b1;
   logic miso, miso_en;

   int n_tests = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [7:0] m_mem [512];
   logic [7:0] wbuf [32];
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] got_byte;
   event       got_evt;

   always #2.5 clk = ~clk;

   eeprom_spi_ctrl #(.WRITE_CYCLES(WC)) dut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
      .spi_mosi(mosi), .spi_miso(miso), .spi_miso_en(miso_en), .wp_n(wp_n)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: pairs each received byte with the queued expectation
   initial begin
      forever begin
         @(got_evt);
         if (exp_q.size() == 0) check("SCB", 1, 0);
         else check(tag_q.pop_front(), got_byte, exp_q.pop_front());
      end
   end

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         ticks(HP);
         rx[i] = miso;
         sck = 1'b1;
         ticks(HP);
         sck = 1'b0;
      end
   endtask

   task automatic cs_begin();
      cs_n = 1'b0;
      ticks(HP);
   endtask

   task automatic cs_end();
      ticks(HP);
      cs_n = 1'b1;
      ticks(2 * HP);
   endtask

   task automatic cmd(input logic [7:0] op);
      logic [7:0] d;
      cs_begin(); xfer(op, d); cs_end();
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] d;
      cs_begin(); xfer(8'h05, d); xfer(8'h00, s); cs_end();
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] d;
      cs_begin(); xfer(8'h01, d); xfer(v, d); cs_end();
   endtask

   task automatic wait_ready();
      logic [7:0] s;
      for (int k = 0; k < 20; k++) begin
         rdsr(s);
         if (!s[0]) return;
      end
      check("R11 ready", 0, 1);
   endtask

   task automatic write_bytes(input logic [8:0] a, input int n, input int extra);
      logic [7:0] d;
      cs_begin();
      xfer(a[8] ? 8'h0A : 8'h02, d);
      xfer(a[7:0], d);
      for (int i = 0; i < n; i++) xfer(wbuf[i], d);
      for (int k = 0; k < extra; k++) begin
         mosi = 1'b1; ticks(HP); sck = 1'b1; ticks(HP); sck = 1'b0;
      end
      cs_end();
   endtask

   task automatic model_write(input logic [8:0] a, input int n);
      for (int i = 0; i < n; i++) m_mem[{a[8:4], 4'(a[3:0] + 4'(i))}] = wbuf[i];
   endtask

   task automatic read_check(input logic [8:0] a, input int n, input string tag);
      logic [7:0] d;
      cs_begin();
      xfer(a[8] ? 8'h0B : 8'h03, d);
      xfer(a[7:0], d);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(m_mem[9'(a + 9'(i))]);
         tag_q.push_back(tag);
         xfer(8'h00, d);
         got_byte = d;
         ->got_evt;
         ticks(1);
      end
      cs_end();
   endtask

   task automatic fill(input int n, input logic [7:0] seed);
      for (int i = 0; i < n; i++) wbuf[i] = seed + 8'(i * 7);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] s, d;
      for (int i = 0; i < 512; i++) m_mem[i] = 8'h00;
      ticks(10);
      rst_n = 1'b1;
      ticks(5);

      // R1 reset state
      check("R1 miso", miso, 0);
      check("R1 miso_en", miso_en, 0);
      rdsr(s); check("R1 status", s, 8'h00);
      read_check(9'h000, 4, "R1 array");

      // R3 write without latch
      fill(2, 8'hA0);
      write_bytes(9'h020, 2, 0);
      rdsr(s); check("R3 status", s, 8'h00);
      read_check(9'h020, 2, "R3 array");
      wrsr(8'h0C);
      rdsr(s); check("R3 status write", s, 8'h00);

      // R2 latch set and clear, R12 output enable
      cmd(8'h06);
      rdsr(s); check("R2 set", s, 8'h02);
      cs_begin(); xfer(8'h05, d);
      ticks(HP); check("R12 en during status", miso_en, 1);
      xfer(8'h00, d); xfer(8'h00, s); cs_end();
      check("R8 repeated status", s, 8'h02);
      check("R12 en after cs", miso_en, 0);
      cmd(8'h04);
      rdsr(s); check("R2 clear", s, 8'h00);

      // R11 accepted write, R4 read back with increment
      cmd(8'h06);
      fill(3, 8'h11);
      write_bytes(9'h010, 3, 0); model_write(9'h010, 3);
      rdsr(s); check("R11 busy", s, 8'h01);
      wait_ready();
      rdsr(s); check("R11 latch auto clear", s, 8'h00);
      read_check(9'h00F, 5, "R4 increment");

      // R5 high address bit
      cmd(8'h06);
      fill(4, 8'h5C);
      write_bytes(9'h1F0, 4, 0); model_write(9'h1F0, 4);
      wait_ready();
      read_check(9'h1F0, 4, "R5 hi read");
      read_check(9'h0F0, 4, "R5 lo read");

      // R4 wrap at top of array
      cmd(8'h06);
      fill(2, 8'hE1);
      write_bytes(9'h1FE, 2, 0); model_write(9'h1FE, 2);
      wait_ready();
      read_check(9'h1FE, 4, "R4 wrap");

      // R6 page wrap and overflow
      cmd(8'h06);
      fill(5, 8'h30);
      write_bytes(9'h02D, 5, 0); model_write(9'h02D, 5);
      wait_ready();
      read_check(9'h020, 16, "R6 page wrap");
      cmd(8'h06);
      fill(18, 8'h81);
      write_bytes(9'h040, 18, 0); model_write(9'h040, 18);
      wait_ready();
      read_check(9'h040, 16, "R6 overflow");

      // R7 partial byte and no data
      cmd(8'h06);
      fill(2, 8'h77);
      write_bytes(9'h060, 2, 3);
      rdsr(s); check("R7 partial", s, 8'h02);
      read_check(9'h060, 2, "R7 partial array");
      write_bytes(9'h060, 0, 0);
      rdsr(s); check("R7 no data", s, 8'h02);
      cmd(8'h04);

      // R8 status write, only guard bits taken
      cmd(8'h06); wrsr(8'hF7); wait_ready();
      rdsr(s); check("R8 guard field", s, 8'h04);

      // R9 quarter guard
      cmd(8'h06);
      fill(1, 8'h9A);
      write_bytes(9'h180, 1, 0);
      rdsr(s); check("R9 quarter blocked", s, 8'h06);
      read_check(9'h180, 1, "R9 quarter array");
      write_bytes(9'h17F, 1, 0); model_write(9'h17F, 1);
      wait_ready();
      read_check(9'h17F, 1, "R9 below quarter");
      // half guard
      cmd(8'h06); wrsr(8'h08); wait_ready();
      cmd(8'h06);
      fill(1, 8'h3B);
      write_bytes(9'h100, 1, 0);
      rdsr(s); check("R9 half blocked", s, 8'h0A);
      write_bytes(9'h0F0, 1, 0); model_write(9'h0F0, 1);
      wait_ready();
      read_check(9'h0F0, 1, "R9 below half");
      read_check(9'h100, 1, "R9 half array");
      // whole guard
      cmd(8'h06); wrsr(8'h0C); wait_ready();
      cmd(8'h06);
      fill(1, 8'hC4);
      write_bytes(9'h000, 1, 0);
      rdsr(s); check("R9 all blocked", s, 8'h0E);
      read_check(9'h000, 1, "R9 all array");
      wrsr(8'h00); wait_ready();
      rdsr(s); check("R9 status not guarded", s, 8'h00);

      // R10 write guard pin
      wp_n = 1'b0;
      cmd(8'h06);
      fill(1, 8'h66);
      write_bytes(9'h070, 1, 0);
      rdsr(s); check("R10 array blocked", s, 8'h02);
      wrsr(8'h0C);
      rdsr(s); check("R10 status blocked", s, 8'h02);
      read_check(9'h070, 1, "R10 array");
      wp_n = 1'b1;
      cmd(8'h04);

      // R11 commands ignored while busy
      cmd(8'h06);
      fill(1, 8'h2D);
      write_bytes(9'h080, 1, 0); model_write(9'h080, 1);
      cmd(8'h06);
      cs_begin(); xfer(8'h03, d); xfer(8'h80, d); xfer(8'h00, d); cs_end();
      check("R11 read ignored", d, 8'h00);
      wait_ready();
      rdsr(s); check("R11 latch set ignored", s, 8'h00);
      read_check(9'h080, 1, "R11 array");

      ticks(10);
      check("SCB drained", exp_q.size(), 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule